// File: doc/BRIEF.md
# Transmit Jabber Guard with Sticky Status

This block sits beside the transmit path of a 10/100 Ethernet PHY. It times every transmit-enable burst. When a 10 Mb/s burst runs past the jabber limit, it forces the outgoing transmit enable low. The transmit enable then stays blocked until the MAC drops its own enable. The block also keeps the sticky status bits that a management read path sees: a jabber flag that latches high and a link flag that latches low.

The jabber limit is a cycle count. It is derived from the clock frequency in kHz and the limit in microseconds, and a bench can shorten it. Reads reach the block as a one-cycle strobe with a 5-bit register address. The jabber flag clears on a read of the basic status address or of the interrupt status address. A level interrupt follows the jabber flag whenever the enable input is high. At 100 Mb/s the timer is held at zero and never fires.

Top module: `jabber_guard`

## Requirements
- R1: With speed10_i=1, tx_en_o equals tx_en_i during the first LIMIT_CYC cycles of a continuous tx_en_i burst. From the following cycle it is forced to 0. A burst of exactly LIMIT_CYC cycles is not cut.
- R2: The cut cycle sets the jabber flag stat_o[1], which reads 1 from the next cycle. The flag then holds until it is cleared as described in R5.
- R3: After a cut, tx_en_o stays 0 while tx_en_i stays high. One low cycle on tx_en_i unblocks the output and restarts the count from zero.
- R4: With speed10_i=0 the timer is held at zero, tx_en_o follows tx_en_i with no time limit, and the jabber flag is never set.
- R5: A read strobe (rd_en_i=1) at address 5'h01 or 5'h11 clears the jabber flag from the next cycle. During the read cycle, stat_o still shows the old value. A read at any other address leaves the flag unchanged. If a cut happens in the same cycle as a clearing read, the flag stays set.
- R6: irq_o is 1 exactly while the jabber flag is set and jab_ie_i=1. It falls when the flag is cleared.
- R7: The link flag stat_o[2] reads 0 after reset. A read at 5'h01 loads it with the current link_ok_i, visible from the next cycle. A cycle with link_ok_i=0 clears it from the next cycle. It then stays 0, even after link_ok_i returns, until the next read at 5'h01. A read at 5'h11 does not reload it.
- R8: stat_o[3] (auto-negotiation able) and stat_o[0] (extended registers present) always read 1.
- R9: While rst_ni is low, and on the first idle cycle after it, stat_o=4'b1001, irq_o=0 and the timer is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| speed10_i | input | 1 | 1 = 10 Mb/s (watchdog armed), 0 = 100 Mb/s |
| link_ok_i | input | 1 | Live link-valid indication |
| rd_en_i | input | 1 | One-cycle management read strobe |
| rd_addr_i | input | 5 | Register address of the read |
| jab_ie_i | input | 1 | Jabber interrupt enable |
| tx_en_o | output | 1 | Gated transmit enable toward the line |
| stat_o | output | 4 | {an_able, link, jabber, ext_cap} |
| irq_o | output | 1 | Level management interrupt |

## Verification
The main function is driven with several burst lengths at 10 Mb/s: shorter than the limit, exactly the limit, and past the limit. These separate an off-by-one in the cut point from a missing cut. A burst broken by a single low cycle shows whether the count restarts. A long burst at 100 Mb/s shows that the watchdog stays disarmed. Reads at the two clearing addresses, at unrelated addresses, and in the same cycle as a cut separate the clear decode from the set-wins priority. A short link dropout, followed by reads at both addresses, shows which read rearms the link flag.

// File: rtl/jg_pkg.sv
package jg_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] ADDR_BSTS = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_ISTS = 5'h11;

  typedef struct packed {
    logic an_able;
    logic link;
    logic jab;
    logic ext_cap;
  } sts_t;
endpackage

// File: rtl/jg_timer.sv
module jg_timer #(
  parameter int unsigned     CW  = 22,
  parameter logic [CW-1:0]   LIM = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic arm_i,
  output logic tx_en_o,
  output logic trip_o
);
  logic [CW-1:0] cnt_q;
  logic          blk_q;

  assign trip_o  = arm_i && tx_en_i && !blk_q && (cnt_q == LIM);
  assign tx_en_o = tx_en_i && !blk_q && !trip_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      if (!tx_en_i || !arm_i) cnt_q <= '0;
      else if (cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
      // stay blocked until the MAC lets go
      if (trip_o)        blk_q <= 1'b1;
      else if (!tx_en_i) blk_q <= 1'b0;
    end
  end

  AST_GATE_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> tx_en_i); // R1
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM); // R1
  AST_CUT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_en_i) && !$past(tx_en_o) && tx_en_i) |-> !tx_en_o); // R3
endmodule

// File: rtl/jg_sticky.sv
module jg_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= set_i | (q_o & ~clr_i); // set beats clear
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o); // R5
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard
  import jg_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 25000,
  parameter int unsigned LIMIT_US = 105000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              speed10_i,
  input  logic              link_ok_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              jab_ie_i,
  output logic              tx_en_o,
  output logic [3:0]        stat_o,
  output logic              irq_o
);
  localparam longint unsigned LIMIT_CYC = longint'(CLK_KHZ) * longint'(LIMIT_US) / 1000;
  localparam int unsigned     CW        = $clog2(LIMIT_CYC + 1);
  localparam logic [CW-1:0]   LIM       = CW'(LIMIT_CYC);

  logic trip;
  logic clr_jab, clr_link;
  logic jab_q, lost_q;
  sts_t sts;

  assign clr_link = rd_en_i && (rd_addr_i == ADDR_BSTS);
  assign clr_jab  = rd_en_i && ((rd_addr_i == ADDR_BSTS) || (rd_addr_i == ADDR_ISTS));

  jg_timer #(.CW(CW), .LIM(LIM)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .arm_i   (speed10_i),
    .tx_en_o (tx_en_o),
    .trip_o  (trip)
  );

  jg_sticky #(.RST_VAL(1'b0)) u_jab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trip),
    .clr_i  (clr_jab),
    .q_o    (jab_q)
  );

  // link kept as a sticky "lost" flag; reset counts as lost
  jg_sticky #(.RST_VAL(1'b1)) u_lost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (~link_ok_i),
    .clr_i  (clr_link),
    .q_o    (lost_q)
  );

  always_comb begin
    sts.an_able = 1'b1;
    sts.link    = ~lost_q;
    sts.jab     = jab_q;
    sts.ext_cap = 1'b1;
  end

  assign stat_o = sts;
  assign irq_o  = jab_q & jab_ie_i;

  AST_FAST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !speed10_i |-> !trip); // R4
  AST_JAB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[1] && !clr_jab) |=> stat_o[1]); // R2
  AST_LINK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o[2] && !clr_link) |=> !stat_o[2]); // R7
endmodule

// File: tb/jabber_guard_tb_top.sv
module jabber_guard_tb_top;
  localparam int LIM = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en_i = 1'b0, speed10_i = 1'b1, link_ok_i = 1'b1;
  logic rd_en_i = 1'b0, jab_ie_i = 1'b0;
  logic [4:0] rd_addr_i = '0;
  logic tx_en_o, irq_o;
  logic [3:0] stat_o;

  always #5 clk_i = ~clk_i;

  jabber_guard #(.CLK_KHZ(1000), .LIMIT_US(20)) dut_i (
    .clk_i, .rst_ni, .tx_en_i, .speed10_i, .link_ok_i,
    .rd_en_i, .rd_addr_i, .jab_ie_i, .tx_en_o, .stat_o, .irq_o
  );

  logic [5:0] exp_q[$];
  string      tag_q[$];
  int total = 0, bad = 0;
  int  run_m = 0;
  bit  blk_m = 0, jab_m = 0, lost_m = 1;
  bit  finished = 0;

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic tx, input logic sp, input logic lk, input logic rd,
                      input logic [4:0] ad, input logic ie, input string tag);
    bit cut, etx, cj, cl;
    @(negedge clk_i);
    tx_en_i = tx; speed10_i = sp; link_ok_i = lk;
    rd_en_i = rd; rd_addr_i = ad; jab_ie_i = ie;
    cut = sp && tx && !blk_m && (run_m == LIM);
    etx = tx && !blk_m && !cut;
    exp_q.push_back({etx, 1'b1, ~lost_m, jab_m, 1'b1, jab_m & ie});
    tag_q.push_back(tag);
    cj = rd && (ad == 5'h01 || ad == 5'h11);
    cl = rd && (ad == 5'h01);
    jab_m  = cut | (jab_m & !cj);
    lost_m = !lk | (lost_m & !cl);
    if (cut) blk_m = 1; else if (!tx) blk_m = 0;
    if (!tx || !sp) run_m = 0; else if (run_m != LIM) run_m++;
  endtask

  task automatic burst(input int n, input logic sp, input logic ie, input string tag);
    for (int i = 0; i < n; i++) step(1, sp, 1, 0, 5'h00, ie, tag);
  endtask

  task automatic idle(input int n, input logic ie, input string tag);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0, 5'h00, ie, tag);
  endtask

  // monitor: pops and compares late in each cycle
  initial forever begin
    logic [5:0] e, act;
    string t;
    @(negedge clk_i);
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = {tx_en_o, stat_o, irq_o};
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s: actual {tx,stat,irq}=%b expected=%b", t, act, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    total++;
    if ({tx_en_o, stat_o, irq_o} !== 6'b010010) begin
      bad++;
      $display("FAIL R9 in reset: actual=%b expected=010010", {tx_en_o, stat_o, irq_o});
    end
    rst_ni = 1'b1;
    step(0, 1, 1, 0, 5'h00, 0, "R9 first cycle after reset");
    step(0, 1, 1, 1, 5'h01, 0, "R7 R8 read before arm");
    step(0, 1, 1, 0, 5'h00, 0, "R7 link armed");
    burst(10, 1, 0, "R1 short burst");
    idle(3, 0, "R1 gap");
    burst(LIM, 1, 0, "R1 exact limit not cut");
    idle(2, 0, "R1 R2 no jabber after exact limit");
    burst(30, 1, 1, "R1 R2 R3 R6 long burst");
    idle(1, 1, "R6 irq level");
    step(0, 1, 1, 1, 5'h05, 1, "R5 read other addr");
    step(0, 1, 1, 1, 5'h10, 1, "R5 read mask addr ignored");
    step(0, 1, 1, 1, 5'h11, 1, "R5 R6 read 11h");
    idle(2, 1, "R5 R6 cleared by 11h");
    burst(25, 1, 0, "R6 masked jabber");
    step(0, 1, 1, 1, 5'h01, 0, "R5 status read shows old");
    idle(1, 0, "R5 cleared by 01h");
    burst(15, 1, 1, "R3 first part");
    step(0, 1, 1, 0, 5'h00, 1, "R3 one low cycle");
    burst(25, 1, 1, "R3 restart from zero");
    idle(1, 1, "R3 unblock");
    step(0, 1, 1, 1, 5'h11, 1, "R5 clear");
    burst(50, 0, 1, "R4 100M no cut");
    idle(2, 1, "R4 no jabber");
    burst(LIM, 1, 1, "R5 setup");
    step(1, 1, 1, 1, 5'h11, 1, "R5 event wins cut cycle");
    step(0, 1, 1, 0, 5'h00, 1, "R5 event wins held");
    step(0, 1, 1, 1, 5'h01, 1, "R5 clear again");
    step(0, 1, 0, 0, 5'h00, 0, "R7 link drop");
    idle(3, 0, "R7 stays low after return");
    step(0, 1, 1, 1, 5'h11, 0, "R7 11h no rearm");
    step(0, 1, 1, 0, 5'h00, 0, "R7 still low");
    step(0, 1, 1, 1, 5'h01, 0, "R7 read shows low");
    idle(2, 0, "R7 R8 rearmed");
    @(negedge clk_i);
    #5;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule